// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Controller

This block watches 32 general-purpose input pins and turns chosen input conditions into latched interrupt requests. Each pin has its own 4-bit sense code. The code selects a rising edge, a falling edge, a high level, a low level or either edge. A separate per-pin detect mask decides whether a pin can raise a new request at all. The latched requests are filtered by a per-pin interrupt-enable mask. The result is a masked status word and one interrupt line.

Software talks to the block over a simple word-addressed register bus. A write takes effect at the next clock edge. Read data is combinational from the addressed register. The interrupt-enable mask has separate write-one-to-set and write-one-to-clear addresses. Latched requests are cleared by writing ones. A service routine reads the masked status, handles the lowest set bit, clears that bit, and repeats until the status reads zero. The pin inputs must already be synchronous to the clock.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset the detect mask, the interrupt-enable mask and every latched request are zero, `irq_out` is low, and each sense register at 0x40, 0x44, 0x48 and 0x4C reads 0x88888888.
- R2: A write to 0x18 sets the interrupt-enable bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their enable bit. Reading 0x18 returns the interrupt-enable mask.
- R3: A write to 0x1C clears the interrupt-enable bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their enable bit. Reading 0x1C returns zero.
- R4: Offset 0x14 is the read/write detect mask. While bit n is 0, pin n latches no new request, whatever its sense code.
- R5: Pin n takes its sense code from bits [4*(n%8)+3 : 4*(n%8)] of the register at 0x40 + 4*(n/8). The four sense registers read back the full 32-bit value last written.
- R6: Code 0x8 latches a request once for each rising edge and code 0x9 once for each falling edge. An edge is found by comparing the pin with its value at the previous clock edge. A pin change driven before clock edge k is visible in the raw request word after edge k.
- R7: Code 0xA latches a request on every clock edge while the pin is high, and code 0xB on every edge while it is low. This holds even in the cycle of a clear.
- R8: Code 0xC latches a request on either edge. All other code values never latch a request.
- R9: Writing 1 to bit n at 0x28 clears the request of pin n. A request detected at the same clock edge wins over the clear. Reading 0x28 returns zero.
- R10: Reading 0x20 returns the raw latched requests. Reading 0x24 returns the latched requests ANDed with the interrupt-enable mask.
- R11: `irq_out` is high exactly when the masked status word is nonzero.
- R12: Reads from any other address, or from an address whose two low bits are not zero, return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 32 | Synchronized GPIO pin levels |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The embedded properties check these rules on every cycle. An enable write sets or clears exactly the bits written as 1. A detected request always lands in the latch, and beats a clear at the same edge. A clear with no new event empties its bit. A pin whose detect mask was off gains no new request. A read of the masked status never shows a disabled pin and always agrees with `irq_out`.

Some behaviour can only be shown by the bench scenarios. These cover each sense code's reaction to actual pin sequences, the level modes re-latching right after a clear, and the invalid codes staying silent. They also cover the reset values of the sense fields and the decoding of unused addresses. A long run with random pins and random register writes is compared against a behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Per-pin sense codes
  typedef enum logic [3:0] {
    SENSE_RISE = 4'h8,
    SENSE_FALL = 4'h9,
    SENSE_HIGH = 4'hA,
    SENSE_LOW  = 4'hB,
    SENSE_BOTH = 4'hC
  } sense_e;

  // Word indices (byte offset / 4) of the register map
  localparam int W_DETMASK = 5;   // 0x14
  localparam int W_EN_SET  = 6;   // 0x18
  localparam int W_EN_CLR  = 7;   // 0x1C
  localparam int W_RAW     = 8;   // 0x20
  localparam int W_STATUS  = 9;   // 0x24
  localparam int W_CLEAR   = 10;  // 0x28
  localparam int W_SENSE0  = 16;  // 0x40

  // One detection decision for one pin
  function automatic logic sense_hit(input logic [3:0] code,
                                     input logic cur, input logic prv);
    logic hit;
    case (sense_e'(code))
      SENSE_RISE: hit = cur & ~prv;
      SENSE_FALL: hit = ~cur & prv;
      SENSE_HIGH: hit = cur;
      SENSE_LOW:  hit = ~cur;
      SENSE_BOTH: hit = cur ^ prv;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_rstsync.sv
module gpio_irq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int FPR   = DATA_W / 4,
  localparam int NSREG = (NPINS + FPR - 1) / FPR
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NPINS-1:0]        raw_pend,
  input  logic [NPINS-1:0]        status,
  output logic [NPINS-1:0]        en_mask,
  output logic [NPINS-1:0]        det_mask,
  output logic [NPINS-1:0]        clr_w1,
  output logic [NSREG*DATA_W-1:0] sense_flat
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] SENSE_RST = {FPR{4'h8}};

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr_en_set, wr_en_clr, wr_mask, wr_clear;
  logic [NPINS-1:0]  wbits;
  logic [NPINS-1:0]  en_q, en_d;
  logic [NPINS-1:0]  mask_q, mask_d;
  logic              en_ld;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wbits   = bus_wdata[NPINS-1:0];

  assign wr_en_set = bus_wr && aligned && (word == WORD_W'(W_EN_SET));
  assign wr_en_clr = bus_wr && aligned && (word == WORD_W'(W_EN_CLR));
  assign wr_mask   = bus_wr && aligned && (word == WORD_W'(W_DETMASK));
  assign wr_clear  = bus_wr && aligned && (word == WORD_W'(W_CLEAR));

  // Next-state: enable mask
  always_comb begin
    en_d = en_q;
    if (wr_en_set) en_d = en_d | wbits;
    if (wr_en_clr) en_d = en_d & ~wbits;
  end
  assign en_ld = wr_en_set | wr_en_clr;

  // Next-state: detect mask
  always_comb begin
    mask_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ld) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= mask_d;
    end
  end

  // Sense registers, one per group of FPR pins
  for (genvar k = 0; k < NSREG; k++) begin : g_sense
    logic              wr_k;
    logic [DATA_W-1:0] sq;
    logic [DATA_W-1:0] sd;

    assign wr_k = bus_wr && aligned && (word == WORD_W'(W_SENSE0 + k));

    always_comb begin
      sd = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sq <= SENSE_RST;
      end else if (wr_k) begin
        sq <= sd;
      end
    end

    assign sense_flat[k*DATA_W +: DATA_W] = sq;
  end

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (word == WORD_W'(W_DETMASK)) bus_rdata = DATA_W'(mask_q);
      if (word == WORD_W'(W_EN_SET))  bus_rdata = DATA_W'(en_q);
      if (word == WORD_W'(W_RAW))     bus_rdata = DATA_W'(raw_pend);
      if (word == WORD_W'(W_STATUS))  bus_rdata = DATA_W'(status);
      for (int k = 0; k < NSREG; k++) begin
        if (word == WORD_W'(W_SENSE0 + k)) bus_rdata = sense_flat[k*DATA_W +: DATA_W];
      end
    end
  end

  assign en_mask  = en_q;
  assign det_mask = mask_q;
  assign clr_w1   = wr_clear ? wbits : '0;

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> ((en_q & $past(wbits)) == $past(wbits)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_clr |=> ((en_q & $past(wbits)) == '0));

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q ^ $past(en_q)) & ~$past(en_ld ? wbits : '0)) == '0);

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  localparam int FPR   = DATA_W / 4,
  localparam int NSREG = (NPINS + FPR - 1) / FPR
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        pin_in,
  input  logic [NPINS-1:0]        det_mask,
  input  logic [NSREG*DATA_W-1:0] sense_flat,
  output logic [NPINS-1:0]        evt
);

  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] prev_d;
  logic [NPINS-1:0] hit;

  always_comb begin
    prev_d = pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_comb begin
      hit[i] = sense_hit(sense_flat[4*i +: 4], pin_in[i], prev_q[i]);
    end
  end

  assign evt = hit & det_mask;

endmodule

// File: rtl/gpio_irq_pending.sv
module gpio_irq_pending #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt,
  input  logic [NPINS-1:0] clr_w1,
  input  logic [NPINS-1:0] en_mask,
  output logic [NPINS-1:0] raw_pend,
  output logic [NPINS-1:0] status,
  output logic             irq
);

  logic [NPINS-1:0] pend_q;
  logic [NPINS-1:0] pend_d;
  logic             pend_ld;

  always_comb begin
    pend_d  = (pend_q & ~clr_w1) | evt;
    pend_ld = |(evt | clr_w1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ld) begin
      pend_q <= pend_d;
    end
  end

  assign raw_pend = pend_q;
  assign status   = pend_q & en_mask;
  assign irq      = |status;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(evt)) == $past(evt));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(clr_w1 & ~evt)) == '0);

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  localparam int FPR   = DATA_W / 4,
  localparam int NSREG = (NPINS + FPR - 1) / FPR
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  logic                    rst_n;
  logic [NPINS-1:0]        en_mask, det_mask, clr_w1;
  logic [NPINS-1:0]        evt, raw_pend, status;
  logic [NSREG*DATA_W-1:0] sense_flat;
  logic                    rd_status;

  gpio_irq_rstsync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .raw_pend   (raw_pend),
    .status     (status),
    .en_mask    (en_mask),
    .det_mask   (det_mask),
    .clr_w1     (clr_w1),
    .sense_flat (sense_flat)
  );

  gpio_irq_detect #(.NPINS(NPINS), .DATA_W(DATA_W)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .det_mask   (det_mask),
    .sense_flat (sense_flat),
    .evt        (evt)
  );

  gpio_irq_pending #(.NPINS(NPINS)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .clr_w1   (clr_w1),
    .en_mask  (en_mask),
    .raw_pend (raw_pend),
    .status   (status),
    .irq      (irq_out)
  );

  assign rd_status = (bus_addr == ADDR_W'(gpio_irq_pkg::W_STATUS * 4));

  // R4
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_pend & ~$past(raw_pend)) & ~$past(det_mask)) == '0);

  // R10
  status_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> ((bus_rdata & ~DATA_W'(en_mask)) == '0));

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> (irq_out == (bus_rdata != '0)));

endmodule

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [31:0] pin_in;
  logic        bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  wire  [31:0] bus_rdata;
  wire         irq_out;

  always #4 clk = ~clk;  // 125 MHz

  gpio_irq_sense u_gpio_irq_sense (
    .clk       (clk),
    .arst_n    (arst_n),
    .pin_in    (pin_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  bit    done   = 0;
  string scen   = "R1";
  logic [31:0] cur_pins = '0;

  // Behavioural reference state
  logic [31:0] m_en, m_mask, m_pend, m_prev;
  logic [31:0] m_sense [4];

  function automatic logic [31:0] m_read(input logic [6:0] a);
    case (a)
      7'h14: return m_mask;
      7'h18: return m_en;
      7'h20: return m_pend;
      7'h24: return m_pend & m_en;
      7'h40: return m_sense[0];
      7'h44: return m_sense[1];
      7'h48: return m_sense[2];
      7'h4C: return m_sense[3];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [6:0] a);
    case (a)
      7'h14: return "R4";
      7'h18: return "R2";
      7'h1C: return "R3";
      7'h20, 7'h24: return "R10";
      7'h28: return "R9";
      7'h40, 7'h44, 7'h48, 7'h4C: return "R5";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] ev;
    logic [31:0] clr;
    if (!arst_n) begin
      m_en = '0; m_mask = '0; m_pend = '0; m_prev = '0;
      for (int k = 0; k < 4; k++) m_sense[k] = 32'h8888_8888;
    end else begin
      ev = '0;
      for (int n = 0; n < 32; n++) begin
        int code;
        code = int'((m_sense[n/8] >> (4*(n%8))) & 32'hF);
        case (code)
          8:  ev[n] = pin_in[n] && !m_prev[n];
          9:  ev[n] = !pin_in[n] && m_prev[n];
          10: ev[n] = pin_in[n];
          11: ev[n] = !pin_in[n];
          12: ev[n] = pin_in[n] != m_prev[n];
          default: ev[n] = 1'b0;
        endcase
      end
      ev  = ev & m_mask;
      clr = (bus_wr && bus_addr == 7'h28) ? bus_wdata : '0;
      m_pend = (m_pend & ~clr) | ev;
      if (bus_wr) begin
        case (bus_addr)
          7'h14: m_mask = bus_wdata;
          7'h18: m_en = m_en | bus_wdata;
          7'h1C: m_en = m_en & ~bus_wdata;
          7'h40: m_sense[0] = bus_wdata;
          7'h44: m_sense[1] = bus_wdata;
          7'h48: m_sense[2] = bus_wdata;
          7'h4C: m_sense[3] = bus_wdata;
          default: ;
        endcase
      end
      m_prev = pin_in;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One bus cycle: compare the state left by the last edge, then drive.
  task automatic cyc(input logic wr, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    chk({"[", scen, "] ", req_of(bus_addr)}, bus_rdata, m_read(bus_addr));
    chk({"[", scen, "] R11"}, {31'h0, irq_out}, {31'h0, |(m_pend & m_en)});
    bus_wr = wr; bus_addr = a; bus_wdata = d; pin_in = cur_pins;
  endtask

  task automatic rd_expect(input logic [6:0] a, input logic [31:0] exp, input string req);
    cyc(1'b0, a, '0);
    cyc(1'b0, a, '0);
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    arst_n = 1'b0; pin_in = '0; bus_wr = 1'b0; bus_addr = 7'h20; bus_wdata = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (5) cyc(1'b0, 7'h20, '0);

    // R1 reset state
    scen = "R1";
    rd_expect(7'h14, 32'h0, "R1 detect mask");
    rd_expect(7'h18, 32'h0, "R1 enable");
    rd_expect(7'h20, 32'h0, "R1 pending");
    rd_expect(7'h40, 32'h8888_8888, "R1 sense0");
    rd_expect(7'h4C, 32'h8888_8888, "R1 sense3");
    chk("R1 irq", {31'h0, irq_out}, 32'h0);

    // R2 / R3 enable set and clear
    scen = "R2";
    cyc(1'b1, 7'h18, 32'h0000_00F0);
    cyc(1'b1, 7'h18, 32'h0000_0001);
    rd_expect(7'h18, 32'h0000_00F1, "R2");
    scen = "R3";
    cyc(1'b1, 7'h1C, 32'h0000_0010);
    rd_expect(7'h18, 32'h0000_00E1, "R3");
    cyc(1'b1, 7'h1C, 32'h0);
    rd_expect(7'h18, 32'h0000_00E1, "R3 zero write");
    rd_expect(7'h1C, 32'h0, "R3 reads zero");
    cyc(1'b1, 7'h1C, 32'hFFFF_FFFF);

    // R5 sense registers; pins 0..7: rise,fall,high,low,both,invalid,rise,rise
    scen = "R5";
    cyc(1'b1, 7'h44, 32'h1234_5678);
    rd_expect(7'h44, 32'h1234_5678, "R5");
    cyc(1'b1, 7'h44, 32'h8888_8888);
    cyc(1'b1, 7'h40, 32'h880C_BA98);
    rd_expect(7'h40, 32'h880C_BA98, "R5");

    // R4 detect mask off: no requests
    scen = "R4";
    cur_pins = 32'h0000_00FF; cyc(1'b0, 7'h20, '0);
    cur_pins = 32'h0000_0000; cyc(1'b0, 7'h20, '0);
    cur_pins = 32'h0000_00AA; cyc(1'b0, 7'h20, '0);
    cur_pins = 32'h0000_0000;
    rd_expect(7'h20, 32'h0, "R4");
    cyc(1'b1, 7'h14, 32'h0000_00FF);
    rd_expect(7'h14, 32'h0000_00FF, "R4 readback");

    // R7 low level latches; clear loses against level
    scen = "R7";
    rd_expect(7'h20, 32'h0000_0008, "R7 low level");
    cyc(1'b1, 7'h28, 32'h0000_0008);
    rd_expect(7'h20, 32'h0000_0008, "R7 relatch after clear");

    // R6 edges
    scen = "R6";
    cur_pins = 32'h0000_0015;
    rd_expect(7'h20, 32'h0000_001D, "R6 rise");
    scen = "R7";
    cyc(1'b1, 7'h28, 32'h0000_00FF);
    rd_expect(7'h20, 32'h0000_000C, "R7 levels");
    scen = "R6";
    cur_pins = 32'h0000_0017; cyc(1'b0, 7'h20, '0);
    cur_pins = 32'h0000_0015;
    rd_expect(7'h20, 32'h0000_000E, "R6 fall");

    // R8 both edges and an invalid code
    scen = "R8";
    cyc(1'b1, 7'h28, 32'h0000_00FF);
    cur_pins = 32'h0000_0025;
    rd_expect(7'h20, 32'h0000_001C, "R8");

    // R9 set beats clear on the same edge
    scen = "R9";
    cur_pins = 32'h0000_0024; cyc(1'b0, 7'h20, '0);
    cur_pins = 32'h0000_0025; cyc(1'b1, 7'h28, 32'h0000_0001);
    rd_expect(7'h20, 32'h0000_001D, "R9");

    // R10 / R11 masked status and interrupt line
    scen = "R10";
    cyc(1'b1, 7'h18, 32'h0000_0001);
    rd_expect(7'h24, 32'h0000_0001, "R10 status");
    chk("R11 irq high", {31'h0, irq_out}, 32'h1);
    cyc(1'b1, 7'h28, 32'h0000_0001);
    rd_expect(7'h24, 32'h0, "R10 status cleared");
    chk("R11 irq low", {31'h0, irq_out}, 32'h0);
    rd_expect(7'h20, 32'h0000_001C, "R10 raw");

    // R12 unmapped addresses
    scen = "R12";
    cyc(1'b1, 7'h30, 32'hFFFF_FFFF);
    cyc(1'b1, 7'h15, 32'h0);
    rd_expect(7'h30, 32'h0, "R12 read");
    rd_expect(7'h14, 32'h0000_00FF, "R12 no side effect");
    rd_expect(7'h19, 32'h0, "R12 misaligned");

    // Random phase against the model
    scen = "R6 random";
    for (int i = 0; i < 4000; i++) begin
      logic [6:0] a;
      int sel;
      sel = int'($urandom_range(0, 15));
      case (sel)
        0: a = 7'h14; 1: a = 7'h18; 2: a = 7'h1C; 3: a = 7'h28;
        4: a = 7'h40; 5: a = 7'h44; 6: a = 7'h48; 7: a = 7'h4C;
        8, 9, 10: a = 7'h20; default: a = 7'h24;
      endcase
      cur_pins = ($urandom_range(0, 3) == 0) ? $urandom() : cur_pins;
      if (sel < 8 && $urandom_range(0, 3) == 0)
        cyc(1'b1, a, (sel >= 4) ? ($urandom() | 32'h8888_8888) & 32'hCFFF_FFFF : $urandom());
      else
        cyc(1'b0, a, '0);
    end
    cyc(1'b0, 7'h20, '0);

    finish_run();
  end

endmodule